// File: doc/BRIEF.md
# Indexed Audio Codec Register File

This block is the control-register front end of an audio codec. It sits on a simple synchronous 32-bit bus, decodes a 64-byte window into sixteen 32-bit direct registers and reaches a second bank of thirty-two 8-bit registers indirectly. An index held in the low bits of direct register 0 picks one bank entry, and direct register 1 works as the data port for that entry.

Each register obeys its own access rule. One bank entry reads back as zero although it accepts writes. Two bank entries never change once reset. The codec version entry keeps a fixed code and lets software flip only a single bit. A direct status word ignores writes. A control word starts a full soft reset when its lowest bit is written as one. The interrupt output is present for integration and is always held low.

Top module: `codec_regfile`

## Requirements
- R1: The direct register number is byte address bits [5:2]. A write to any direct register other than 1, 2 and 4 stores all 32 bits. A read strobe loads `rd_data` at the next clock edge with the addressed register, and `rd_data` holds its value while no read is strobed.
- R2: The bank index is bits [4:0] of direct register 0. A read of direct register 1 returns the indexed bank entry zero-extended to 32 bits. A write to direct register 1 stores `wr_data[7:0]` into the indexed entry. Direct register 0 itself reads back all 32 written bits.
- R3: Bank entry 3 is write-only: a data-port read at index 3 returns zero.
- R4: Bank entries 11 and 25 are read-only: data-port writes leave them unchanged (0x00 and 0xA0 after reset).
- R5: A data-port write at index 12 stores (wr_data & 0x40) | 0x8A.
- R6: Writes to direct register 2 are ignored, so it keeps reading 0.
- R7: A write to direct register 4 stores wr_data & 0x7F. When wr_data bit 0 is 1, every direct and bank register first returns to its reset value, and register 4 then takes the masked value.
- R8: After the active-low asynchronous reset, every direct register reads 0, bank entry 12 reads 0x8A, bank entry 25 reads 0xA0, every other bank entry reads 0, and `rd_data` is 0.
- R9: `irq` is 0 at all times.
- R10: When a read and a write hit the same register in one cycle, the read returns the value from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 6 | Byte address within the window |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Read data, registered one clock after the strobe |
| irq | output | 1 | Interrupt request, tied inactive |

## Verification
Direct registers get all-ones, mixed-bit and sparse words so that a stuck or dropped data bit shows up, and two distinct addresses show whether the decode aliases. The data port is tried at a plain index, at the write-only entry, at the two read-only entries and at the version entry. At the version entry, values with bit 6 set, with bit 6 clear and with every other bit set separate the kept bit from the fixed code. The control word is written once with bit 0 clear and once with bit 0 set, which separates masking from soft reset, and a read in the same cycle as a write shows the order of the two operations.

// File: rtl/codec_regfile_pkg.sv
package codec_regfile_pkg;

    localparam int unsigned BUS_W  = 32;
    localparam int unsigned DIR_N  = 16;
    localparam int unsigned IND_N  = 32;
    localparam int unsigned IND_W  = 8;
    localparam int unsigned IDX_W  = $clog2(IND_N);
    localparam int unsigned DSEL_W = $clog2(DIR_N);
    localparam int unsigned ADDR_W = DSEL_W + 2;

    // direct register roles
    localparam logic [DSEL_W-1:0] DIR_INDEX  = DSEL_W'(0);
    localparam logic [DSEL_W-1:0] DIR_PORT   = DSEL_W'(1);
    localparam logic [DSEL_W-1:0] DIR_STATUS = DSEL_W'(2);
    localparam logic [DSEL_W-1:0] DIR_CTRL   = DSEL_W'(4);

    // bank entry roles
    localparam logic [IDX_W-1:0] IND_WONLY = IDX_W'(3);
    localparam logic [IDX_W-1:0] IND_RO_A  = IDX_W'(11);
    localparam logic [IDX_W-1:0] IND_VER   = IDX_W'(12);
    localparam logic [IDX_W-1:0] IND_CHIP  = IDX_W'(25);

    typedef logic [DIR_N-1:0][BUS_W-1:0] dir_arr_t;
    typedef logic [IND_N-1:0][IND_W-1:0] ind_arr_t;

    typedef struct packed {
        dir_arr_t          dir;
        ind_arr_t          ind;
        logic [BUS_W-1:0]  rdat;
    } regs_t;

endpackage

// File: rtl/codec_ind_wpolicy.sv
// Decides whether a data-port write lands and what value it stores.
module codec_ind_wpolicy
    import codec_regfile_pkg::*;
#(
    parameter logic [IND_W-1:0] CODEC_VER = 8'h8A,
    parameter logic [IND_W-1:0] KEEP_MASK = 8'h40
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [IND_W-1:0] din,
    output logic             allow,
    output logic [IND_W-1:0] dout
);
    always_comb begin
        allow = 1'b1;
        dout  = din;
        if (idx == IND_RO_A || idx == IND_CHIP) begin
            allow = 1'b0;
        end else if (idx == IND_VER) begin
            dout = (din & KEEP_MASK) | CODEC_VER;
        end
    end
endmodule

// File: rtl/codec_ind_rpolicy.sv
// Shapes the data-port read value for the selected bank entry.
module codec_ind_rpolicy
    import codec_regfile_pkg::*;
(
    input  logic [IDX_W-1:0] idx,
    input  logic [IND_W-1:0] stored,
    output logic [BUS_W-1:0] dout
);
    always_comb begin
        if (idx == IND_WONLY) begin
            dout = '0;
        end else begin
            dout = {{(BUS_W-IND_W){1'b0}}, stored};
        end
    end
endmodule

// File: rtl/codec_regfile.sv
module codec_regfile
    import codec_regfile_pkg::*;
#(
    parameter logic [IND_W-1:0] CODEC_VER = 8'h8A,
    parameter logic [IND_W-1:0] CHIP_VER  = 8'hA0,
    parameter int unsigned      CTRL_BITS = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [BUS_W-1:0]  wr_data,
    input  logic              rd_en,
    output logic [BUS_W-1:0]  rd_data,
    output logic              irq
);
    localparam logic [BUS_W-1:0] CTRL_MASK = BUS_W'((64'd1 << CTRL_BITS) - 64'd1);

    regs_t             st_d, st_q;
    ind_arr_t          ind_rst;
    logic [DSEL_W-1:0] dsel;
    logic [IDX_W-1:0]  idx;
    logic              w_allow;
    logic [IND_W-1:0]  w_val;
    logic [BUS_W-1:0]  port_rd;
    logic              unused_byte_lane;

    assign dsel             = addr[ADDR_W-1:2];
    assign unused_byte_lane = ^addr[1:0];
    assign idx              = st_q.dir[DIR_INDEX][IDX_W-1:0];

    // reset image of the bank
    for (genvar i = 0; i < IND_N; i++) begin : g_ind_rst
        if (i == int'(IND_VER)) begin : g_ver
            assign ind_rst[i] = CODEC_VER;
        end else if (i == int'(IND_CHIP)) begin : g_chip
            assign ind_rst[i] = CHIP_VER;
        end else begin : g_zero
            assign ind_rst[i] = '0;
        end
    end

    codec_ind_wpolicy #(.CODEC_VER(CODEC_VER)) u_wpol (
        .idx   (idx),
        .din   (wr_data[IND_W-1:0]),
        .allow (w_allow),
        .dout  (w_val)
    );

    codec_ind_rpolicy u_rpol (
        .idx    (idx),
        .stored (st_q.ind[idx]),
        .dout   (port_rd)
    );

    always_comb begin
        st_d = st_q;
        if (rd_en) begin
            st_d.rdat = (dsel == DIR_PORT) ? port_rd : st_q.dir[dsel];
        end
        if (wr_en) begin
            if (dsel == DIR_PORT) begin
                if (w_allow) begin
                    st_d.ind[idx] = w_val;
                end
            end else if (dsel == DIR_CTRL) begin
                if (wr_data[0]) begin
                    st_d.dir = '0;
                    st_d.ind = ind_rst;
                end
                st_d.dir[DIR_CTRL] = wr_data & CTRL_MASK;
            end else if (dsel != DIR_STATUS) begin
                st_d.dir[dsel] = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.dir  <= '0;
            st_q.ind  <= ind_rst;
            st_q.rdat <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data = st_q.rdat;
    assign irq     = 1'b0;
endmodule

// File: rtl/codec_regfile_chk.sv
module codec_regfile_chk
    import codec_regfile_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [DSEL_W-1:0] word,
    input logic              wr_en,
    input logic              rd_en,
    input logic [BUS_W-1:0]  rd_data,
    input logic              irq,
    input logic [IDX_W-1:0]  idx,
    input logic [BUS_W-1:0]  dir2,
    input logic [BUS_W-1:0]  dir4,
    input logic [IND_W-1:0]  ind11,
    input logic [IND_W-1:0]  ind12,
    input logic [IND_W-1:0]  ind25
);
    AST_WONLY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && word == DIR_PORT && idx == IND_WONLY) |=> rd_data == '0); // R3

    AST_RO_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && word == DIR_PORT && (idx == IND_RO_A || idx == IND_CHIP))
        |=> (ind11 == $past(ind11) && ind25 == $past(ind25))); // R4

    AST_VER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (ind12 & 8'hBF) == 8'h8A); // R5

    AST_STATUS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && word == DIR_STATUS) |=> $stable(dir2)); // R6

    AST_CTRL_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
        dir4[BUS_W-1:7] == '0); // R7

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !irq); // R9
endmodule

bind codec_regfile codec_regfile_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .word    (addr[5:2]),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .rd_data (rd_data),
    .irq     (irq),
    .idx     (st_q.dir[0][4:0]),
    .dir2    (st_q.dir[2]),
    .dir4    (st_q.dir[4]),
    .ind11   (st_q.ind[11]),
    .ind12   (st_q.ind[12]),
    .ind25   (st_q.ind[25])
);

// File: tb/codec_regfile_test.sv
module codec_regfile_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;
    logic        irq;
    int          checks = 0;
    int          errors = 0;

    always #5 clk = ~clk;

    codec_regfile uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int reg_no, input logic [31:0] d);
        @(negedge clk);
        addr = 6'(reg_no << 2); wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int reg_no, output logic [31:0] d);
        @(negedge clk);
        addr = 6'(reg_no << 2); rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic rd_ind(input int idx, output logic [31:0] d);
        wr(0, 32'(idx));
        rd(1, d);
    endtask

    task automatic wr_ind(input int idx, input logic [7:0] v);
        wr(0, 32'(idx));
        wr(1, {24'hABCDEF, v});
    endtask

    task automatic t_reset;
        logic [31:0] v;
        check("R8 rd_data", rd_data, 32'h0);
        check("R9 irq", {31'b0, irq}, 32'h0);
        rd(5, v);  check("R8 dir5", v, 32'h0);
        rd(0, v);  check("R8 dir0", v, 32'h0);
        rd_ind(12, v); check("R8 ind12", v, 32'h8A);
        rd_ind(25, v); check("R8 ind25", v, 32'hA0);
        rd_ind(7, v);  check("R8 ind7", v, 32'h0);
    endtask

    task automatic t_direct;
        logic [31:0] v;
        wr(5, 32'hDEADBEEF);
        wr(15, 32'h12345678);
        wr(7, 32'hFFFFFFFF);
        rd(5, v);  check("R1 dir5", v, 32'hDEADBEEF);
        rd(15, v); check("R1 dir15", v, 32'h12345678);
        rd(7, v);  check("R1 dir7", v, 32'hFFFFFFFF);
        repeat (3) @(negedge clk);
        check("R1 hold", rd_data, 32'hFFFFFFFF);
    endtask

    task automatic t_port;
        logic [31:0] v;
        wr(0, 32'hFFFFFF07);
        wr(1, 32'h000001A5);
        rd(1, v); check("R2 ind7", v, 32'hA5);
        rd(0, v); check("R2 dir0 full", v, 32'hFFFFFF07);
        rd_ind(8, v); check("R2 ind8", v, 32'h0);
    endtask

    task automatic t_rules;
        logic [31:0] v;
        wr_ind(3, 8'h55);
        rd(1, v); check("R3 wonly", v, 32'h0);
        wr_ind(11, 8'hFF);
        rd(1, v); check("R4 ind11", v, 32'h0);
        wr_ind(25, 8'h00);
        rd(1, v); check("R4 ind25", v, 32'hA0);
        wr_ind(12, 8'hFF);
        rd(1, v); check("R5 ff", v, 32'hCA);
        wr(1, 32'h0);
        rd(1, v); check("R5 00", v, 32'h8A);
        wr(1, 32'hBF);
        rd(1, v); check("R5 bf", v, 32'h8A);
        wr(2, 32'h1234);
        rd(2, v); check("R6 status", v, 32'h0);
    endtask

    task automatic t_ctrl;
        logic [31:0] v;
        wr(5, 32'h0BADF00D);
        wr_ind(7, 8'h3C);
        wr(4, 32'hFFFFFF0E);
        rd(4, v); check("R7 mask", v, 32'h0E);
        rd(5, v); check("R7 no reset", v, 32'h0BADF00D);
        wr(4, 32'h00000083);
        rd(4, v); check("R7 soft reg4", v, 32'h03);
        rd(5, v); check("R7 soft dir5", v, 32'h0);
        rd(0, v); check("R7 soft dir0", v, 32'h0);
        rd(1, v); check("R7 soft ind0", v, 32'h0);
        rd_ind(7, v);  check("R7 soft ind7", v, 32'h0);
        rd_ind(12, v); check("R7 soft ind12", v, 32'h8A);
        rd_ind(25, v); check("R7 soft ind25", v, 32'hA0);
    endtask

    task automatic t_same_cycle;
        logic [31:0] v;
        wr(6, 32'h11111111);
        @(negedge clk);
        addr = 6'd24; wr_data = 32'h22222222; wr_en = 1'b1; rd_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        check("R10 old value", rd_data, 32'h11111111);
        rd(6, v); check("R10 new value", v, 32'h22222222);
        check("R9 irq", {31'b0, irq}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_direct();
        t_port();
        t_rules();
        t_ctrl();
        t_same_cycle();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule